// File: doc/BRIEF.md
# Lookup-Table Random Phase Generator

This block gives a holographic frame pipeline one pseudo-random unit phasor for each pixel request. It does this without any trigonometric core and without any random number hardware. A phase index walks a prime-length table by a fixed stride. Each index addresses a cosine ROM and a sine ROM, and both ROMs are read in the same cycle. The requester gets a registered, signed phasor pair, together with the pixel number and subframe number that the phasor belongs to.

The table length, stride and starting offset are elaboration parameters, and the table length must be prime. Because the stride is coprime to the length, every table entry is visited exactly once before the pattern repeats. The walk carries on across pixel and subframe boundaries. As a result, each subframe of a frame sees a different phase pattern until the table has been used up. A frame-start pulse restarts the walk from the seed offset and clears the counters. A stall input freezes the whole block.

The ROM contents are computed at elaboration. Each entry is the cosine or sine of 2πk/L scaled by 2^(W-1)-1 and rounded to the nearest code.

Top module: `lut_phase_gen`

## Requirements
- R1: While reset is low and after it is released, valid_o, pixel_o and subframe_o are 0. The first accepted request is then served from table index SEED.
- R2: A phasor served from index k has cos_o within 1 LSB of round(cos(2πk/L)·(2^(W-1)-1)) and sin_o within 1 LSB of the same expression with sin. Its squared magnitude lies between (2^(W-1)-2)^2 and (2^(W-1))^2.
- R3: After each accepted request the index becomes (idx + STRIDE) mod L. Any L consecutive requests use every table entry exactly once, and request number L+1 repeats the phasor of the first.
- R4: A request is accepted when req_i=1, stall_i=0 and frame_start_i=0. valid_o is 1 on the clock edge after acceptance. cos_o and sin_o come from the same table index.
- R5: While stall_i=1 and frame_start_i=0, the outputs cos_o, sin_o, valid_o, pixel_o and subframe_o hold, and the index and counters do not move.
- R6: With no accepted request and no stall, valid_o is 0 on the next edge and the index does not advance.
- R7: pixel_o carries the zero-based count of accepted requests within the current subframe. It wraps from PIX_PER_SUB-1 to 0.
- R8: subframe_o goes up by one when pixel_o wraps. It wraps from SUBS-1 to 0.
- R9: The index is not reloaded at subframe boundaries or idle cycles. It resumes where the last accepted request left it.
- R10: frame_start_i=1 reloads the index with SEED, clears the counters, pixel_o and subframe_o, and drives valid_o to 0. A request presented in the same cycle is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Restart the phase walk and counters |
| req_i | input | 1 | Pixel phasor request |
| stall_i | input | 1 | Freeze index, counters and outputs |
| valid_o | output | 1 | Phasor output valid |
| cos_o | output | W | Signed cosine word |
| sin_o | output | W | Signed sine word |
| pixel_o | output | PW | Pixel number within subframe |
| subframe_o | output | SW | Subframe number within frame |

## Verification
Each accepted request produces its phasor, pixel tag and subframe tag one edge later. The bench drives inputs on the falling edge and reads the results on the next falling edge, halfway between the accepting edge and the following one. A stall or frame-start pulse likewise acts on the next edge, so its outputs are checked one falling edge after it is applied. During a held stall, the outputs are compared on every falling edge against the values captured before the stall. Expected table indices and phasor codes come from a reference walk and real-valued cosine and sine computed in the bench.

// File: rtl/lut_phase_pkg.sv
`timescale 1ns/1ps
package lut_phase_pkg;

  // quantised phasor component for table entry k
  function automatic int phasor_code(int k, int len, int w, bit want_sin);
    real scale, ang, v;
    scale = real'((1 << (w - 1)) - 1);
    ang   = 2.0 * 3.14159265358979323846 * real'(k) / real'(len);
    v     = (want_sin ? $sin(ang) : $cos(ang)) * scale;
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return -$rtoi(0.5 - v);
  endfunction

endpackage

// File: rtl/phase_addr_gen.sv
`timescale 1ns/1ps
module phase_addr_gen #(
  parameter int TAB_LEN = 2003,
  parameter int STRIDE  = 769,
  parameter int SEED    = 0,
  parameter int IDXW    = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            step_i,
  output logic [IDXW-1:0] idx_o
);
  localparam logic [IDXW:0]   LEN_W  = (IDXW+1)'(TAB_LEN);
  localparam logic [IDXW:0]   STEP_W = (IDXW+1)'(STRIDE);
  localparam logic [IDXW-1:0] SEED_W = IDXW'(SEED);

  logic [IDXW-1:0] idx_q;
  logic [IDXW:0]   sum;
  logic [IDXW-1:0] nxt;

  // modular add by one conditional subtract
  always_comb begin
    sum = {1'b0, idx_q} + STEP_W;
    nxt = (sum >= LEN_W) ? IDXW'(sum - LEN_W) : IDXW'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= SEED_W;
    else if (load_i) idx_q <= SEED_W;
    else if (step_i) idx_q <= nxt;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/phase_counters.sv
`timescale 1ns/1ps
module phase_counters #(
  parameter int PIX_PER_SUB = 1048576,
  parameter int SUBS        = 24,
  parameter int PW          = 20,
  parameter int SW          = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [PW-1:0] pix_o,
  output logic [SW-1:0] sub_o
);
  localparam logic [PW-1:0] PIX_LAST = PW'(PIX_PER_SUB - 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBS - 1);

  logic [PW-1:0] pix_q;
  logic [SW-1:0] sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q <= '0;
      sub_q <= '0;
    end else if (clear_i) begin
      pix_q <= '0;
      sub_q <= '0;
    end else if (step_i) begin
      if (pix_q == PIX_LAST) begin
        pix_q <= '0;
        sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
      end else begin
        pix_q <= pix_q + 1'b1;
      end
    end
  end

  assign pix_o = pix_q;
  assign sub_o = sub_q;
endmodule

// File: rtl/phase_rom.sv
`timescale 1ns/1ps
module phase_rom #(
  parameter int TAB_LEN = 2003,
  parameter int W       = 16,
  parameter int IDXW    = 11,
  parameter bit IS_SIN  = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [IDXW-1:0]     idx_i,
  output logic signed [W-1:0] q_o
);
  logic signed [W-1:0] tab [TAB_LEN];

  for (genvar k = 0; k < TAB_LEN; k++) begin : g_ent
    localparam int CODE = lut_phase_pkg::phasor_code(k, TAB_LEN, W, IS_SIN);
    assign tab[k] = CODE[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (en_i)  q_o <= tab[idx_i];
  end
endmodule

// File: rtl/lut_phase_gen.sv
`timescale 1ns/1ps
module lut_phase_gen #(
  parameter int TAB_LEN     = 2003,
  parameter int STRIDE      = 769,
  parameter int SEED        = 0,
  parameter int W           = 16,
  parameter int PIX_PER_SUB = 1048576,
  parameter int SUBS        = 24,
  localparam int IDXW       = $clog2(TAB_LEN),
  localparam int PW         = (PIX_PER_SUB > 1) ? $clog2(PIX_PER_SUB) : 1,
  localparam int SW         = (SUBS > 1) ? $clog2(SUBS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_start_i,
  input  logic                req_i,
  input  logic                stall_i,
  output logic                valid_o,
  output logic signed [W-1:0] cos_o,
  output logic signed [W-1:0] sin_o,
  output logic [PW-1:0]       pixel_o,
  output logic [SW-1:0]       subframe_o
);
  logic            acc;
  logic [IDXW-1:0] idx_q;
  logic [PW-1:0]   pix_cnt;
  logic [SW-1:0]   sub_cnt;
  logic            valid_q;
  logic [PW-1:0]   pix_q;
  logic [SW-1:0]   sub_q;

  assign acc = req_i & ~stall_i & ~frame_start_i;

  phase_addr_gen #(
    .TAB_LEN(TAB_LEN), .STRIDE(STRIDE), .SEED(SEED), .IDXW(IDXW)
  ) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(frame_start_i),
    .step_i(acc), .idx_o(idx_q)
  );

  phase_counters #(
    .PIX_PER_SUB(PIX_PER_SUB), .SUBS(SUBS), .PW(PW), .SW(SW)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(frame_start_i),
    .step_i(acc), .pix_o(pix_cnt), .sub_o(sub_cnt)
  );

  for (genvar c = 0; c < 2; c++) begin : g_rom
    logic signed [W-1:0] q;
    phase_rom #(
      .TAB_LEN(TAB_LEN), .W(W), .IDXW(IDXW), .IS_SIN(c == 1)
    ) u_rom (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(acc), .idx_i(idx_q), .q_o(q)
    );
  end
  assign cos_o = g_rom[0].q;
  assign sin_o = g_rom[1].q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pix_q   <= '0;
      sub_q   <= '0;
    end else if (frame_start_i) begin
      valid_q <= 1'b0;
      pix_q   <= '0;
      sub_q   <= '0;
    end else if (!stall_i) begin
      valid_q <= acc;
      if (acc) begin
        pix_q <= pix_cnt;
        sub_q <= sub_cnt;
      end
    end
  end

  assign valid_o    = valid_q;
  assign pixel_o    = pix_q;
  assign subframe_o = sub_q;
endmodule

// File: rtl/lut_phase_gen_chk.sv
`timescale 1ns/1ps
module lut_phase_gen_chk #(
  parameter int TAB_LEN     = 13,
  parameter int W           = 12,
  parameter int PIX_PER_SUB = 7,
  parameter int SUBS        = 3,
  parameter int IDXW        = 4,
  parameter int PW          = 3,
  parameter int SW          = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                frame_start_i,
  input logic                req_i,
  input logic                stall_i,
  input logic                valid_o,
  input logic signed [W-1:0] cos_o,
  input logic signed [W-1:0] sin_o,
  input logic [PW-1:0]       pixel_o,
  input logic [SW-1:0]       subframe_o,
  input logic [IDXW-1:0]     idx_i
);
  localparam longint SCALE = (longint'(1) << (W - 1)) - 1;
  localparam logic [PW-1:0] PIX_LAST = PW'(PIX_PER_SUB - 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBS - 1);

  logic   acc;
  longint mag2;
  assign acc  = req_i & ~stall_i & ~frame_start_i;
  assign mag2 = longint'(cos_o) * longint'(cos_o) + longint'(sin_o) * longint'(sin_o);

  a_r4_valid_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> valid_o);

  a_r6_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !stall_i && !frame_start_i) |=> (!valid_o && $stable(idx_i)));

  a_r5_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !frame_start_i) |=> ($stable(cos_o) && $stable(sin_o) &&
      $stable(valid_o) && $stable(pixel_o) && $stable(subframe_o) && $stable(idx_i)));

  a_r10_frame_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (!valid_o && pixel_o == '0 && subframe_o == '0));

  a_r7_pixel_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && acc) |=>
      (pixel_o == (($past(pixel_o) == PIX_LAST) ? '0 : $past(pixel_o) + 1'b1)));

  a_r8_sub_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && acc && pixel_o == PIX_LAST) |=>
      (subframe_o == (($past(subframe_o) == SUB_LAST) ? '0 : $past(subframe_o) + 1'b1)));

  a_r8_sub_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && acc && pixel_o != PIX_LAST) |=> $stable(subframe_o));

  a_r2_on_circle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (mag2 >= (SCALE - 1) * (SCALE - 1) && mag2 <= (SCALE + 1) * (SCALE + 1)));

  a_r3_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_i < IDXW'(TAB_LEN));
endmodule

bind lut_phase_gen lut_phase_gen_chk #(
  .TAB_LEN(TAB_LEN), .W(W), .PIX_PER_SUB(PIX_PER_SUB), .SUBS(SUBS),
  .IDXW(IDXW), .PW(PW), .SW(SW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
  .req_i(req_i), .stall_i(stall_i), .valid_o(valid_o), .cos_o(cos_o),
  .sin_o(sin_o), .pixel_o(pixel_o), .subframe_o(subframe_o), .idx_i(idx_q)
);

// File: tb/sim_lut_phase_gen.sv
`timescale 1ns/1ps
module sim_lut_phase_gen;
  localparam int L    = 13;
  localparam int S    = 5;
  localparam int SEED = 3;
  localparam int W    = 12;
  localparam int PIX  = 7;
  localparam int SUBS = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_start_i = 1'b0;
  logic req_i = 1'b0;
  logic stall_i = 1'b0;
  logic valid_o;
  logic signed [W-1:0] cos_o, sin_o;
  logic [2:0] pixel_o;
  logic [1:0] subframe_o;

  always #10 clk_i = ~clk_i;

  lut_phase_gen #(
    .TAB_LEN(L), .STRIDE(S), .SEED(SEED), .W(W), .PIX_PER_SUB(PIX), .SUBS(SUBS)
  ) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
    .req_i(req_i), .stall_i(stall_i), .valid_o(valid_o), .cos_o(cos_o),
    .sin_o(sin_o), .pixel_o(pixel_o), .subframe_o(subframe_o)
  );

  int n_chk = 0, n_fail = 0;
  int m_idx, m_pix, m_sub;
  bit done = 1'b0;

  function automatic int ref_code(int k, bit want_sin);
    real a, v;
    a = 2.0 * 3.14159265358979323846 * real'(k) / real'(L);
    v = (want_sin ? $sin(a) : $cos(a)) * real'((1 << (W - 1)) - 1);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

  function automatic bit near(int a, int b);
    return (a - b <= 1) && (b - a <= 1);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_idx = SEED; m_pix = 0; m_sub = 0;
  endtask

  // check one served phasor against the model, then advance the model
  task automatic chk_phasor(string req);
    chk(valid_o == 1'b1, req, "valid", int'(valid_o), 1);
    chk(near(int'(cos_o), ref_code(m_idx, 0)), req, "cos", int'(cos_o), ref_code(m_idx, 0));
    chk(near(int'(sin_o), ref_code(m_idx, 1)), req, "sin", int'(sin_o), ref_code(m_idx, 1));
    chk(int'(pixel_o) == m_pix, req, "pixel", int'(pixel_o), m_pix);
    chk(int'(subframe_o) == m_sub, req, "subframe", int'(subframe_o), m_sub);
    m_idx = (m_idx + S) % L;
    if (m_pix == PIX - 1) begin
      m_pix = 0;
      m_sub = (m_sub == SUBS - 1) ? 0 : m_sub + 1;
    end else m_pix++;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(valid_o == 1'b0, "R1", "valid in reset", int'(valid_o), 0);
    chk(pixel_o == '0, "R1", "pixel in reset", int'(pixel_o), 0);
    chk(subframe_o == '0, "R1", "subframe in reset", int'(subframe_o), 0);
    rst_ni = 1'b1;
    model_reset();
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R1", "valid after reset", int'(valid_o), 0);
  endtask

  // single request: valid one edge later, low again after
  task automatic t_single();
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    chk_phasor("R1 R4 seed");
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R4", "valid after single", int'(valid_o), 0);
  endtask

  // 2L back-to-back requests: values, coverage, period, subframe wrap
  task automatic t_sweep();
    bit seen [L];
    int first_cos, first_sin, hit;
    for (int k = 0; k < L; k++) seen[k] = 1'b0;
    first_cos = 0; first_sin = 0;
    req_i = 1'b1;
    for (int i = 0; i < 2 * L; i++) begin
      @(negedge clk_i);
      if (i < L) begin
        hit = -1;
        for (int k = 0; k < L; k++)
          if (near(int'(cos_o), ref_code(k, 0)) && near(int'(sin_o), ref_code(k, 1))) hit = k;
        chk(hit >= 0 && !seen[hit], "R3", "unique entry", hit, m_idx);
        if (hit >= 0) seen[hit] = 1'b1;
        if (i == 0) begin first_cos = int'(cos_o); first_sin = int'(sin_o); end
      end
      if (i == L) begin
        chk(int'(cos_o) == first_cos, "R3", "period cos", int'(cos_o), first_cos);
        chk(int'(sin_o) == first_sin, "R3", "period sin", int'(sin_o), first_sin);
      end
      chk_phasor("R2 R7 R8 R9 sweep");
    end
    req_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_gap();
    req_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(valid_o == 1'b0, "R6", "valid idle", int'(valid_o), 0);
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    chk_phasor("R6 R9 resume");
  endtask

  task automatic t_stall();
    int c0, s0, p0, v0;
    req_i = 1'b1;
    @(negedge clk_i);
    chk_phasor("R5 before stall");
    c0 = int'(cos_o); s0 = int'(sin_o); p0 = int'(pixel_o); v0 = int'(valid_o);
    stall_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(int'(cos_o) == c0, "R5", "cos held", int'(cos_o), c0);
      chk(int'(sin_o) == s0, "R5", "sin held", int'(sin_o), s0);
      chk(int'(pixel_o) == p0, "R5", "pixel held", int'(pixel_o), p0);
      chk(int'(valid_o) == v0, "R5", "valid held", int'(valid_o), v0);
    end
    stall_i = 1'b0;
    @(negedge clk_i);
    req_i = 1'b0;
    chk_phasor("R5 after stall");
    @(negedge clk_i);
  endtask

  task automatic t_frame();
    req_i = 1'b1;
    @(negedge clk_i);
    chk_phasor("R10 before frame");
    frame_start_i = 1'b1;
    @(negedge clk_i);
    frame_start_i = 1'b0;
    chk(valid_o == 1'b0, "R10", "valid on frame start", int'(valid_o), 0);
    chk(pixel_o == '0, "R10", "pixel cleared", int'(pixel_o), 0);
    chk(subframe_o == '0, "R10", "subframe cleared", int'(subframe_o), 0);
    model_reset();
    @(negedge clk_i);
    req_i = 1'b0;
    chk_phasor("R10 seed reload");
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_sweep();
    t_gap();
    t_stall();
    t_frame();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule